// File: doc/BRIEF.md
# Three-Block Interleaved Round Sequencer

This controller drives a round-based block-cipher datapath that keeps three independent 128-bit blocks in flight. The blocks are interleaved through a loop of three registers, so a round for all three blocks takes three clock cycles. The controller does not touch any data. It only produces the strobes and selects that the datapath needs: when to take new blocks, which round key to apply, when to skip the column-mixing stage, when to load the result register, and when the result is valid.

After reset the sequencer stays idle while key expansion is busy. When key expansion finishes, it runs fixed frames of `NUM_SLOTS*(NUM_ROUNDS+1)` cycles, which is 33 cycles with the defaults. Each frame has four phases:
- an input phase of three cycles,
- a run phase through the middle rounds,
- a last-round phase in which mixing is bypassed and the result register loads,
- an emit phase of three cycles with the output valid.

The frame then starts again without a gap. A single frame counter sets the phase lengths. Logic that watches the counter produces one phase-end bit, and that bit is the only thing that moves the state machine.

Top module: `ilv_round_ctl`

## Requirements
- R1: While reset is high, and in the cycle after reset, `din_en`, `out_valid`, `out_load` and `mix_bypass` are 0 and `round_idx` is 0.
- R2: While idle, the sequencer stays idle as long as `key_busy` is 1, and all of its outputs stay at their reset values.
- R3: If `key_busy` is 0 while idle, the frame starts on the next cycle, which is frame cycle 0. `din_en` is 1 in frame cycles 0, 1 and 2 and is 0 in every other frame cycle.
- R4: In frame cycle c, `round_idx` equals c divided by 3, rounded down. It runs from 0 to 10.
- R5: `mix_bypass` and `out_load` are 1 in exactly frame cycles 27, 28 and 29. In those cycles `round_idx` is 9.
- R6: `out_valid` is 1 in exactly frame cycles 30, 31 and 32, and it rises in the cycle after `out_load` falls.
- R7: After frame cycle 32 the next cycle is frame cycle 0 of a new frame, so frames repeat every 33 cycles with no idle gap.
- R8: Once a frame has started, `key_busy` has no effect. Only reset returns the sequencer to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_busy | input | 1 | High while key expansion is still running |
| din_en | output | 1 | The datapath accepts a new input block this cycle |
| out_valid | output | 1 | The result register holds a finished block |
| out_load | output | 1 | Load enable for the result register |
| mix_bypass | output | 1 | Bypass the column-mixing stage in this round |
| round_idx | output | 4 | Index of the round key to apply |

## Verification
The bench keeps its own count of the frame cycle from the cycle in which `key_busy` is released. It compares all five outputs against that count in every cycle across three frames. Any error in the counter or the state shows up as a phase boundary that is off by at least one cycle, and the check for that same cycle reports it. If the sequencer leaves a frame early or skips the wrap, the mismatch appears in `round_idx` or `din_en` within three cycles. Toggling `key_busy` in the middle of a frame, and resetting in the middle of a frame, show whether the idle state can be reached by any path other than reset.

// File: rtl/ilv_ctl_pkg.sv
package ilv_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_RUN  = 3'd2,
    ST_LAST = 3'd3,
    ST_EMIT = 3'd4
  } ctl_state_e;

  // Frame length for a given number of interleaved blocks and rounds.
  function automatic int frame_len(input int slots, input int rounds);
    return slots * (rounds + 1);
  endfunction

  // Frame cycles that end a phase: input, run, last round, emit.
  function automatic int load_end(input int slots);
    return slots - 1;
  endfunction

  function automatic int run_end(input int slots, input int rounds);
    return frame_len(slots, rounds) - 2 * slots - 1;
  endfunction

  function automatic int last_end(input int slots, input int rounds);
    return frame_len(slots, rounds) - slots - 1;
  endfunction

endpackage

// File: rtl/ilv_frame_counter.sv
module ilv_frame_counter #(
  parameter int FRAME_LEN = 33,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst || !run)          cnt <= '0;
    else if (cnt == LAST_CNT) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ilv_phase_fsm.sv
module ilv_phase_fsm
  import ilv_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_busy,
  input  logic       phase_end,
  output ctl_state_e state
);
  ctl_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: nxt = key_busy  ? ST_IDLE : ST_LOAD;
      ST_LOAD: nxt = phase_end ? ST_RUN  : ST_LOAD;
      ST_RUN:  nxt = phase_end ? ST_LAST : ST_RUN;
      ST_LAST: nxt = phase_end ? ST_EMIT : ST_LAST;
      ST_EMIT: nxt = phase_end ? ST_LOAD : ST_EMIT;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/ilv_round_ctl.sv
module ilv_round_ctl
  import ilv_ctl_pkg::*;
#(
  parameter int NUM_SLOTS  = 3,
  parameter int NUM_ROUNDS = 10,
  parameter int RIDX_W     = $clog2(NUM_ROUNDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_busy,
  output logic              din_en,
  output logic              out_valid,
  output logic              out_load,
  output logic              mix_bypass,
  output logic [RIDX_W-1:0] round_idx
);
  localparam int FRAME_LEN = frame_len(NUM_SLOTS, NUM_ROUNDS);
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] C_LOAD_END = CNT_W'(load_end(NUM_SLOTS));
  localparam logic [CNT_W-1:0] C_RUN_END  = CNT_W'(run_end(NUM_SLOTS, NUM_ROUNDS));
  localparam logic [CNT_W-1:0] C_LAST_END = CNT_W'(last_end(NUM_SLOTS, NUM_ROUNDS));
  localparam logic [CNT_W-1:0] C_EMIT_END = CNT_W'(FRAME_LEN - 1);

  ctl_state_e       fsm_state;
  logic [CNT_W-1:0] frame_cnt;
  logic             phase_end;
  logic             frame_active;

  assign frame_active = (fsm_state != ST_IDLE);

  // A single trigger bit, decoded from the counter, moves the state machine.
  assign phase_end = (frame_cnt == C_LOAD_END) || (frame_cnt == C_RUN_END) ||
                     (frame_cnt == C_LAST_END) || (frame_cnt == C_EMIT_END);

  ilv_frame_counter #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .run (frame_active),
    .cnt (frame_cnt)
  );

  ilv_phase_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .key_busy  (key_busy),
    .phase_end (phase_end),
    .state     (fsm_state)
  );

  // Each round lasts one slot of NUM_SLOTS cycles, so the three blocks share a key.
  assign round_idx  = frame_active ? RIDX_W'(frame_cnt / CNT_W'(NUM_SLOTS)) : '0;
  assign din_en     = (fsm_state == ST_LOAD);
  assign mix_bypass = (fsm_state == ST_LAST);
  assign out_load   = (fsm_state == ST_LAST);
  assign out_valid  = (fsm_state == ST_EMIT);
endmodule

// File: rtl/ilv_round_ctl_chk.sv
module ilv_round_ctl_chk
  import ilv_ctl_pkg::*;
#(
  parameter int NUM_ROUNDS = 10,
  parameter int RIDX_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              key_busy,
  input logic              din_en,
  input logic              out_valid,
  input logic              out_load,
  input logic              mix_bypass,
  input logic [RIDX_W-1:0] round_idx,
  input ctl_state_e        fsm_state
);
  // R2: the sequencer holds idle while key expansion is busy
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == ST_IDLE && key_busy) |=> (fsm_state == ST_IDLE));

  // R3: the input window opens right after the emit phase
  a_r3_din_after_emit: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> din_en);

  // R4: the round index only steps forward by one or restarts at zero
  a_r4_ridx_step: assert property (@(posedge clk) disable iff (rst)
    (round_idx != $past(round_idx)) |->
      (round_idx == $past(round_idx) + 1'b1 || round_idx == '0));

  // R5: the bypassed round is the last one before the output
  a_r5_bypass_round: assert property (@(posedge clk) disable iff (rst)
    $rose(mix_bypass) |-> (round_idx == RIDX_W'(NUM_ROUNDS - 1)));

  // R6: valid output follows the result-register load
  a_r6_valid_after_load: assert property (@(posedge clk) disable iff (rst)
    $fell(out_load) |-> out_valid);

  // R3 R6: phases never overlap
  a_r6_phase_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({din_en, out_load, out_valid}));

  // R8: a running frame never falls back to idle on its own
  a_r8_no_exit: assert property (@(posedge clk) disable iff (rst)
    (fsm_state != ST_IDLE) |=> (fsm_state != ST_IDLE));
endmodule

bind ilv_round_ctl ilv_round_ctl_chk #(.NUM_ROUNDS(NUM_ROUNDS), .RIDX_W(RIDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .key_busy   (key_busy),
  .din_en     (din_en),
  .out_valid  (out_valid),
  .out_load   (out_load),
  .mix_bypass (mix_bypass),
  .round_idx  (round_idx),
  .fsm_state  (fsm_state)
);

// File: tb/test_ilv_round_ctl.sv
`timescale 1ns/1ps
module test_ilv_round_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_busy = 1'b1;
  logic       din_en, out_valid, out_load, mix_bypass;
  logic [3:0] round_idx;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ilv_round_ctl i_ilv_round_ctl (
    .clk(clk), .rst(rst), .key_busy(key_busy),
    .din_en(din_en), .out_valid(out_valid), .out_load(out_load),
    .mix_bypass(mix_bypass), .round_idx(round_idx)
  );

  task automatic check_idle(input string req);
    checks++;
    if (din_en || out_valid || out_load || mix_bypass || round_idx != 0) begin
      errors++;
      $display("FAIL %s idle: got din=%0b val=%0b load=%0b byp=%0b ridx=%0d exp all 0",
               req, din_en, out_valid, out_load, mix_bypass, round_idx);
    end
  endtask

  // Compare every output against frame cycle c computed here.
  task automatic check_frame(input int c, input string req);
    logic e_din, e_val, e_last;
    int   e_ridx;
    e_din  = (c < 3);
    e_last = (c >= 27 && c <= 29);
    e_val  = (c >= 30);
    e_ridx = c / 3;
    checks++;
    if (din_en !== e_din) begin errors++;
      $display("FAIL R3 %s c=%0d din_en got %0b exp %0b", req, c, din_en, e_din); end
    checks++;
    if (round_idx !== 4'(e_ridx)) begin errors++;
      $display("FAIL R4 %s c=%0d round_idx got %0d exp %0d", req, c, round_idx, e_ridx); end
    checks++;
    if (mix_bypass !== e_last || out_load !== e_last) begin errors++;
      $display("FAIL R5 %s c=%0d byp/load got %0b%0b exp %0b%0b", req, c,
               mix_bypass, out_load, e_last, e_last); end
    checks++;
    if (out_valid !== e_val) begin errors++;
      $display("FAIL R6 %s c=%0d out_valid got %0b exp %0b", req, c, out_valid, e_val); end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 check_idle("R1");
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1 check_idle("R1");
    // R2: held idle while key expansion runs
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1 check_idle("R2");
    end
    // R3 R7: release, then follow three frames
    @(negedge clk) key_busy = 1'b0;
    for (int k = 0; k < 99; k++) begin
      @(posedge clk); #1;
      check_frame(k % 33, (k >= 33) ? "R7" : "R3");
    end
    // R8: key_busy toggling during a frame changes nothing
    for (int k = 99; k < 132; k++) begin
      @(negedge clk) key_busy = ((k % 5) < 2);
      @(posedge clk); #1;
      check_frame(k % 33, "R8");
    end
    // R1: reset mid-frame, then stay idle while busy
    @(negedge clk) begin key_busy = 1'b1; rst = 1'b1; end
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #1;
      if (k == 4) ;
    end
    check_idle("R1");
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1 check_idle("R2");
    end
    // R3: restart aligns to frame cycle 0 again
    @(negedge clk) key_busy = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      check_frame(k % 33, "R3");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule